// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Coherent Result Readout

This block is the digital half of a 10-bit successive-approximation converter. Software talks to it through four byte-wide registers: a control/status register, a channel/alignment register and two result bytes. It divides the system clock down to a conversion clock and runs single or back-to-back conversions. It drives a 10-bit trial code toward an external DAC and reads back a single comparator bit. The analog channel it selects is held for the whole of a conversion.

A read-order interlock keeps the two result bytes from the same conversion. Reading the low byte freezes both bytes, and reading the high byte releases them. A conversion that ends while the bytes are frozen is thrown away, but it still raises the completion flag and can still raise the interrupt.

The sequencer has three states. `S_IDLE` waits for a start request and moves to `S_SAMPLE` (transition *launch*). `S_SAMPLE` counts two conversion-clock ticks and moves to `S_SEARCH` (transition *settle*). `S_SEARCH` resolves one bit per tick, MSB first. After the last bit it goes back to `S_SAMPLE` in free-running mode (transition *rerun*) or to `S_IDLE` otherwise (transition *finish*). From any state, a disabled converter returns to `S_IDLE` (transition *abort*).

Top module: `sar_conv_ctrl`

## Requirements
- R1: Control register (address 0) bit 7 enables the converter. While it is 0, `chan_out` and `ref_out` read 0, a start write is ignored (bit 6 reads 0), and clearing it mid-conversion ends the conversion without setting the flag.
- R2: Writing 1 to control bit 6 while enabled starts a conversion. Bit 6 reads 1 from the next cycle until the conversion ends, and then reads 0 in single mode.
- R3: The channel field (address 1, bits 2:0) may be written during a conversion. The running conversion keeps its old channel on `chan_out`, and the new value applies from the next conversion.
- R4: Each conversion takes two sample ticks, then ten search ticks, MSB first. A trial bit is kept when `cmp_in` is 1 (input at or above the trial code), so the result equals the code the comparator tracks.
- R5: With address 1 bit 7 clear, the result is right-aligned: address 2 holds result[7:0] and address 3 holds {6'b0, result[9:8]}. With that bit set, address 3 holds result[9:2] and address 2 holds {result[1:0], 6'b0}.
- R6: A read of address 2 blocks result updates to both bytes until address 3 is read.
- R7: A conversion that completes while updates are blocked leaves both bytes unchanged but still sets the flag (control bit 4).
- R8: Control bit 5 selects free-running mode. Conversions repeat, bit 6 stays 1, and the result bytes keep refreshing. Clearing bit 5 lets the current conversion finish, and then bit 6 returns to 0.
- R9: Control bits 2:0 select the conversion-clock divide ratio: codes 0 to 7 give 2, 2, 4, 8, 16, 32, 64 and 128 system clocks. The prescaler is held in reset while the converter is disabled, so a conversion lasts between 11 and 12 ratio periods plus a few cycles.
- R10: Writing 1 to control bit 4 clears the flag. `irq` equals the flag ANDed with control bit 3.
- R11: After reset, all four registers read 0, and `irq` and `trial_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives interlock side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on `addr` |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `trial_code` |
| trial_code | output | 10 | Trial code to the DAC |
| chan_out | output | 3 | Active analog channel |
| ref_out | output | 2 | Reference selection |
| irq | output | 1 | Completion interrupt request |

## Verification
The comparator is modelled from a per-channel target code. Targets of 0, full scale, alternating-bit patterns and the values on either side of mid-scale are used; each forces a different keep/clear pattern in the search, so a mis-ordered or dropped bit decision shows up as a wrong code. Every target is read back in both alignments, which separates a byte-placement fault from a search fault. A channel rewrite during a conversion, a conversion ending inside the low-then-high read window, and a free-running run whose target is changed between reads separate the deferred channel switch, the interlock, and the refresh behaviour. Conversion length is timed at two divide ratios to tell the select codes apart.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int RES_W = 10;
    localparam int SAMPLE_TICKS = 2;
    localparam int DIV_W = 7;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SAMPLE = 2'd1,
        S_SEARCH = 2'd2
    } sar_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MUX  = 2'd1;
    localparam logic [1:0] A_LOW  = 2'd2;
    localparam logic [1:0] A_HIGH = 2'd3;
endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
    parameter int DW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] mask;

    // ratio 2^sel, with code 0 sharing the divide-by-2 setting
    always_comb begin
        if (sel == 3'd0) mask = DW'(1);
        else             mask = DW'((1 << sel) - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign tick = en && ((cnt & mask) == mask);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int W = RES_W,
    parameter int NSAMP = SAMPLE_TICKS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         go,
    input  logic         free_run,
    input  logic         tick,
    input  logic         cmp_in,
    output logic [W-1:0] trial_code,
    output logic         busy,
    output logic         load,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int IW = $clog2(W);
    localparam int SW = $clog2(NSAMP + 1);

    sar_state_e    st, st_n;
    logic [W-1:0]  code, code_n;
    logic [IW-1:0] idx, idx_n;
    logic [SW-1:0] smp, smp_n;
    logic [W-1:0]  trial;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            code <= '0;
            idx  <= '0;
            smp  <= '0;
        end else begin
            st   <= st_n;
            code <= code_n;
            idx  <= idx_n;
            smp  <= smp_n;
        end
    end

    always_comb begin
        st_n   = st;
        code_n = code;
        idx_n  = idx;
        smp_n  = smp;
        done   = 1'b0;
        load   = 1'b0;
        trial  = code;
        result = code;
        unique case (st)
            S_IDLE: begin
                code_n = '0;
                if (go) begin
                    st_n  = S_SAMPLE;
                    smp_n = '0;
                    load  = 1'b1;
                end
            end
            S_SAMPLE: begin
                if (tick) begin
                    if (smp == SW'(NSAMP - 1)) begin
                        st_n   = S_SEARCH;
                        code_n = W'(1) << (W - 1);
                        idx_n  = IW'(W - 1);
                    end else begin
                        smp_n = smp + 1'b1;
                    end
                end
            end
            S_SEARCH: begin
                if (tick) begin
                    if (!cmp_in) trial[idx] = 1'b0;
                    if (idx == '0) begin
                        done   = 1'b1;
                        result = trial;
                        code_n = '0;
                        if (free_run) begin
                            st_n  = S_SAMPLE;
                            smp_n = '0;
                            load  = 1'b1;
                        end else begin
                            st_n = S_IDLE;
                        end
                    end else begin
                        trial[idx - 1'b1] = 1'b1;
                        code_n = trial;
                        idx_n  = idx - 1'b1;
                    end
                end
            end
            default: st_n = S_IDLE;
        endcase
        if (!en) begin
            st_n   = S_IDLE;
            code_n = '0;
            done   = 1'b0;
            load   = 1'b0;
        end
    end

    assign trial_code = code;
    assign busy = (st != S_IDLE);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic [2:0]       chan_out,
    output logic [1:0]       ref_out,
    output logic             irq
);
    logic             en, free, ie, flag, start_req, left, lock;
    logic [2:0]       div, mux_ch, chan_act;
    logic [1:0]       ref_sel;
    logic [RES_W-1:0] res_q, seq_res;
    logic             tick, busy, load, done;
    logic             ctrl_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    sar_prescale #(.DW(DIV_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(div), .tick(tick)
    );

    sar_seq #(.W(RES_W), .NSAMP(SAMPLE_TICKS)) i_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .go(start_req), .free_run(free),
        .tick(tick), .cmp_in(cmp_in), .trial_code(trial_code), .busy(busy),
        .load(load), .done(done), .result(seq_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; free <= 1'b0; ie <= 1'b0; flag <= 1'b0;
            start_req <= 1'b0; div <= '0;
            left <= 1'b0; ref_sel <= '0; mux_ch <= '0;
            res_q <= '0; lock <= 1'b0; chan_act <= '0;
        end else begin
            if (done && !free) start_req <= 1'b0;
            if (ctrl_wr) begin
                en   <= wdata[7];
                free <= wdata[5];
                ie   <= wdata[3];
                div  <= wdata[2:0];
                if (wdata[7] && wdata[6]) start_req <= 1'b1;
                if (!wdata[7])            start_req <= 1'b0;
            end
            if (done)                         flag <= 1'b1;
            else if (ctrl_wr && wdata[4])     flag <= 1'b0;
            if (wr_en && addr == A_MUX) begin
                left    <= wdata[7];
                ref_sel <= wdata[6:5];
                mux_ch  <= wdata[2:0];
            end
            if (load) chan_act <= mux_ch;
            if (done && !lock) res_q <= seq_res;
            if (rd_en && addr == A_LOW)       lock <= 1'b1;
            else if (rd_en && addr == A_HIGH) lock <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {en, start_req, free, flag, ie, div};
            A_MUX:   rdata = {left, ref_sel, 2'b00, mux_ch};
            A_LOW:   rdata = left ? {res_q[1:0], 6'b0} : res_q[7:0];
            default: rdata = left ? res_q[9:2] : {6'b0, res_q[9:8]};
        endcase
    end

    assign chan_out = en ? (busy ? chan_act : mux_ch) : 3'd0;
    assign ref_out  = en ? ref_sel : 2'd0;
    assign irq      = flag && ie;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk
    import sar_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             busy,
    input logic             done,
    input logic             load,
    input logic             free,
    input logic             start_req,
    input logic             ctrl_wr,
    input logic             lock,
    input logic             flag,
    input logic             tick,
    input logic [2:0]       chan_out,
    input logic [RES_W-1:0] res_q,
    input logic [RES_W-1:0] trial_code
);
    // R1: a disabled converter drops its trial code
    a_r1_off_clears_trial: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> trial_code == '0);

    // R2: single-mode completion releases the start bit
    a_r2_done_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
        done && !free && !ctrl_wr |=> !start_req);

    // R3: channel held while a conversion runs
    a_r3_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        en && busy && !done && !load |=> !en || $stable(chan_out));

    // R6: interlock freezes the stored result
    a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(res_q));

    // R7: every completion raises the flag
    a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    // R9: divide ratio is at least two
    a_r9_tick_sparse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .done(done), .load(load),
    .free(free), .start_req(start_req), .ctrl_wr(ctrl_wr), .lock(lock),
    .flag(flag), .tick(tick), .chan_out(chan_out), .res_q(res_q),
    .trial_code(trial_code)
);

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/1ps
module test_sar_conv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cmp_in;
    logic [9:0] trial_code;
    logic [2:0] chan_out;
    logic [1:0] ref_out;
    logic       irq;

    sar_conv_ctrl i_sar_conv_ctrl (.*);

    always #2.5 clk = ~clk;

    logic [9:0] tgt [8];
    assign cmp_in = (tgt[chan_out] >= trial_code);

    typedef struct packed { logic left; logic [9:0] val; } exp_t;
    exp_t q[$];
    int checks = 0, failures = 0, mon_cnt = 0;
    bit mon_on = 0;
    logic [7:0] cfg;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_lo(input exp_t e);
        return e.left ? {e.val[1:0], 6'b0} : e.val[7:0];
    endfunction
    function automatic logic [7:0] exp_hi(input exp_t e);
        return e.left ? e.val[9:2] : {6'b0, e.val[9:8]};
    endfunction

    task automatic wait_idle(output int cyc);
        logic [7:0] s;
        cyc = 0;
        do begin rd(0, s); cyc++; end while (s[6] && cyc < 5000);
    endtask

    // monitor: consumes completions, compares against the scoreboard
    initial begin
        logic [7:0] lo, hi;
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_on && irq) begin
                rd(2, lo); rd(3, hi);
                if (q.size() == 0) chk(0, "R4 scoreboard empty", 0, 1);
                else begin
                    e = q.pop_front();
                    chk(lo == exp_lo(e), "R4/R5 low byte", lo, exp_lo(e));
                    chk(hi == exp_hi(e), "R4/R5 high byte", hi, exp_hi(e));
                end
                wr(0, cfg | 8'h10);
                mon_cnt++;
            end
        end
    end

    task automatic convert(input logic [2:0] ch, input logic left);
        int n;
        wr(1, {left, 2'b01, 2'b00, ch});
        q.push_back({left, tgt[ch]});
        n = mon_cnt;
        wr(0, cfg | 8'h40);
        wait (mon_cnt != n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d, lo0, hi0;
        int cyc, n;
        logic [9:0] pats [6] = '{10'h000, 10'h3FF, 10'h2AA, 10'h155, 10'h200, 10'h1FF};
        for (int i = 0; i < 8; i++) tgt[i] = 10'(i * 97 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk(d == 8'h00, "R11 register reset", d, 0);
        end
        chk(irq == 1'b0 && trial_code == '0, "R11 irq/trial reset", {irq, trial_code}, 0);

        // R1 disabled: selections hidden, start ignored
        wr(1, 8'b0100_0101);
        chk(chan_out == 0 && ref_out == 0, "R1 outputs off while disabled", {ref_out, chan_out}, 0);
        wr(0, 8'h40);
        rd(0, d);
        chk(d[6] == 1'b0, "R1 start ignored while disabled", d[6], 0);
        wr(0, 8'h80);
        @(negedge clk);
        chk(chan_out == 3'd5 && ref_out == 2'd2, "R1 selections applied when enabled", {ref_out, chan_out}, {2'd2, 3'd5});

        // R1 abort mid-conversion, slowest divider
        wr(0, 8'hC7);
        repeat (60) @(negedge clk);
        wr(0, 8'h07);
        rd(0, d);
        chk(d[6] == 1'b0 && d[4] == 1'b0, "R1 abort clears start, no flag", d, 8'h07);
        chk(trial_code == '0, "R1 trial code cleared on abort", trial_code, 0);

        // R2 start bit set then cleared
        cfg = 8'h88;
        wr(0, cfg | 8'h40);
        rd(0, d);
        chk(d[6] == 1'b1, "R2 start bit reads 1 while running", d[6], 1);
        wait_idle(cyc);
        rd(0, d);
        chk(d[6] == 1'b0 && d[4] == 1'b1, "R2 start cleared and flag set at end", d[6:4], 3'b001);
        chk(irq == 1'b1, "R10 irq when flag and enable", irq, 1);
        wr(0, cfg | 8'h10);
        chk(irq == 1'b0, "R10 flag cleared by writing 1", irq, 0);

        // R4/R5 scoreboard conversions in both alignments
        mon_on = 1;
        for (int i = 0; i < 6; i++) begin
            tgt[i] = pats[i];
            convert(3'(i), 1'b0);
            convert(3'(i), 1'b1);
        end

        // R3 deferred channel switch
        tgt[1] = 10'h123; tgt[2] = 10'h2F0;
        wr(1, 8'h01);
        q.push_back({1'b0, tgt[1]});
        n = mon_cnt;
        wr(0, cfg | 8'h40);
        repeat (6) @(negedge clk);
        wr(1, 8'h02);
        chk(chan_out == 3'd1, "R3 channel held during conversion", chan_out, 1);
        wait (mon_cnt != n);
        convert(3'd2, 1'b0);
        mon_on = 0;

        // R9 conversion length at two ratios
        for (int k = 0; k < 2; k++) begin
            logic [2:0] sel = (k == 0) ? 3'd3 : 3'd7;
            int r = 1 << sel;
            wr(0, 8'h80 | 8'(sel) | 8'h10);
            cyc = 0;
            wr(0, 8'hC0 | 8'(sel));
            while (!(i_sar_conv_ctrl.rdata === 8'hxx) && cyc < 4000) begin
                @(negedge clk); addr = 0; #1;
                if (rdata[4]) break;
                cyc++;
            end
            chk(cyc >= 11 * r && cyc <= 12 * r + 4, "R9 conversion length vs ratio", cyc, 12 * r);
            wr(0, 8'h90 | 8'(sel));
        end

        // R6/R7 interlock and lost result
        cfg = 8'h80;
        tgt[0] = 10'h2C5;
        wr(1, 8'h00);
        wr(0, cfg | 8'h50);
        wait_idle(cyc);
        rd(2, lo0);
        chk(lo0 == 8'hC5, "R6 low byte before lock", lo0, 8'hC5);
        tgt[0] = 10'h13A;
        wr(0, cfg | 8'h50);
        wait_idle(cyc);
        rd(0, d);
        chk(d[4] == 1'b1, "R7 flag set on lost result", d[4], 1);
        rd(3, hi0);
        chk(hi0 == 8'h02, "R6 high byte unchanged under lock", hi0, 8'h02);
        rd(2, d);
        chk(d == 8'hC5, "R7 low byte kept old conversion", d, 8'hC5);
        rd(3, d);
        wr(0, cfg | 8'h50);
        wait_idle(cyc);
        rd(2, lo0); rd(3, hi0);
        chk({hi0[1:0], lo0} == 10'h13A, "R6 updates resume after high read", {hi0[1:0], lo0}, 10'h13A);

        // R8 free-running refresh
        tgt[0] = 10'h0F0;
        wr(0, 8'hF0);
        repeat (200) @(negedge clk);
        rd(0, d);
        chk(d[6] == 1'b1, "R8 start stays set in free-run", d[6], 1);
        rd(2, lo0); rd(3, hi0);
        chk({hi0[1:0], lo0} == 10'h0F0, "R8 free-run result", {hi0[1:0], lo0}, 10'h0F0);
        tgt[0] = 10'h30F;
        repeat (200) @(negedge clk);
        rd(2, lo0); rd(3, hi0);
        chk({hi0[1:0], lo0} == 10'h30F, "R8 free-run refreshes", {hi0[1:0], lo0}, 10'h30F);
        wr(0, 8'h80);
        wait_idle(cyc);
        rd(0, d);
        chk(d[6] == 1'b0 && cyc < 5000, "R8 stop after free-run cleared", d[6], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule